// File: doc/BRIEF.md
# Register-Amount Rotate-Right Execute Stage

This block is the execute stage for one 32-bit data-processing operation: rotate a source value right by an amount held in a second register, and optionally update the condition flags. Each transaction carries the full instruction word, the value to rotate, the amount operand, the current N/Z/C/V flags and a condition-pass bit produced upstream. The stage confirms that the word is the register-amount rotate form. It then produces the destination register index, the rotated result, a register write enable, the next flag values and a flag write enable.

The input and output sides are valid/ready streams. A transaction is accepted on a rising edge where `in_valid` and `in_ready` are both high. The result appears one edge later with `out_valid` high. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the stage sustains one transaction per cycle when the consumer never stalls.

Top module: `rorx_exec_unit`

## Requirements
- R1: The result is `in_value` rotated right by n, where n = `in_amount[7:0]` mod 32 (equivalently `in_amount[4:0]`). Bits leaving bit 0 re-enter at bit 31, and `in_amount[31:5]` has no effect.
- R2: When n is 0, the result equals `in_value` and the carry-out equals the incoming C flag.
- R3: When n is nonzero, the carry-out equals bit n-1 of `in_value`.
- R4: For a legal word with S (bit 20) set and condition pass high, `out_flags_we` is 1 and the flags update. The flag vector is ordered [3]=N, [2]=Z, [1]=C, [0]=V. N becomes result bit 31, Z becomes 1 exactly when the result is zero, and C becomes the carry-out.
- R5: When S is 0, `out_flags_we` is 0 and `out_flags` equals `in_flags`.
- R6: The V flag (`out_flags[0]`) always equals the incoming V.
- R7: The word is legal when `instr & 32'h0FEF00F0 == 32'h01A00070`. Bits [31:28] are free. A legal word with condition pass high gives `out_rd_we`=1 and `out_rd` = bits [15:12].
- R8: An illegal word gives `out_illegal`=1, `out_rd_we`=0 and `out_flags_we`=0, and `out_flags` equals `in_flags`.
- R9: With condition pass low, `out_rd_we`=0 and `out_flags_we`=0, and `out_flags` equals `in_flags`.
- R10: `out_valid` rises on the edge after an accepted transaction. `in_ready` = !`out_valid` || `out_ready`. While stalled, all outputs stay stable.
- R11: A synchronous active-high reset clears `out_valid`, all output data and both write enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Stage can accept a transaction |
| in_instr | input | 32 | Instruction word |
| in_value | input | 32 | Value to rotate |
| in_amount | input | 32 | Register supplying the rotate amount |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| in_cond_pass | input | 1 | Condition evaluated as passing |
| out_valid | output | 1 | Output transaction present |
| out_ready | input | 1 | Consumer accepts output |
| out_rd | output | 4 | Destination register index |
| out_result | output | 32 | Rotated value |
| out_rd_we | output | 1 | Destination write enable |
| out_flags | output | 4 | Next flags {N,Z,C,V} |
| out_flags_we | output | 1 | Flag write enable |
| out_illegal | output | 1 | Word is not the register rotate form |

## Verification
Directed amounts of 0, 32, 257, 1, 16 and 31 separate the modulo-32 reduction from a plain low-byte rotate. They also separate the zero-amount carry rule from the bit n-1 rule. A zero operand and operands with bit 31 set or clear show Z and N tracking the result. Words with S clear, with one fixed bit flipped, or with condition pass low show that each suppression acts on its own. A long random run with random back-pressure compares every output on every cycle against a queue-free behavioural model, so a stalled output that changes or a lost transaction is caught.

// File: rtl/rorx_pkg.sv
package rorx_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 4;
  localparam int FLAG_W = 4;

  // fixed-field mask and match value of the register-amount rotate word
  localparam logic [INSTR_W-1:0] FIX_MASK  = 32'h0FEF_00F0;
  localparam logic [INSTR_W-1:0] FIX_MATCH = 32'h01A0_0070;
  localparam int SET_FLAGS_BIT = 20;
  localparam int DEST_LSB = 12;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic                 legal;
    logic                 set_flags;
    logic [REG_IDX_W-1:0] dest;
  } dec_t;
endpackage

// File: rtl/rorx_decode.sv
module rorx_decode
  import rorx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.legal     = ((instr & FIX_MASK) == FIX_MATCH);
    dec.set_flags = instr[SET_FLAGS_BIT];
    dec.dest      = instr[DEST_LSB +: REG_IDX_W];
  end
endmodule

// File: rtl/rorx_barrel.sv
module rorx_barrel #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/rorx_flags.sv
module rorx_flags
  import rorx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] result,
  input  logic         amt_zero,
  input  flags_t       flags_in,
  input  logic         update,
  output flags_t       flags_out
);
  logic carry;

  // for a nonzero rotate, the last bit shifted out lands in the top position
  assign carry = amt_zero ? flags_in.c : result[W-1];

  always_comb begin
    flags_out = flags_in;
    if (update) begin
      flags_out.n = result[W-1];
      flags_out.z = (result == '0);
      flags_out.c = carry;
    end
  end
endmodule

// File: rtl/rorx_exec_unit.sv
module rorx_exec_unit
  import rorx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSTR_W-1:0]   in_instr,
  input  logic [W-1:0]         in_value,
  input  logic [W-1:0]         in_amount,
  input  logic [FLAG_W-1:0]    in_flags,
  input  logic                 in_cond_pass,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [REG_IDX_W-1:0] out_rd,
  output logic [W-1:0]         out_result,
  output logic                 out_rd_we,
  output logic [FLAG_W-1:0]    out_flags,
  output logic                 out_flags_we,
  output logic                 out_illegal
);
  localparam int AW = $clog2(W);

  dec_t         dec;
  logic [AW-1:0] amt;
  logic [W-1:0] rot;
  flags_t       nxt_flags;
  logic         do_write;
  logic         do_flags;
  logic         accept;

  rorx_decode u_dec (.instr(in_instr), .dec(dec));

  // low-byte amount mod W reduces to the low AW bits
  assign amt = in_amount[AW-1:0];

  rorx_barrel #(.W(W)) u_rot (.din(in_value), .amt(amt), .dout(rot));

  assign do_write = dec.legal && in_cond_pass;
  assign do_flags = do_write && dec.set_flags;

  rorx_flags #(.W(W)) u_flg (
    .result   (rot),
    .amt_zero (amt == '0),
    .flags_in (flags_t'(in_flags)),
    .update   (do_flags),
    .flags_out(nxt_flags)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_rd       <= '0;
      out_result   <= '0;
      out_rd_we    <= 1'b0;
      out_flags    <= '0;
      out_flags_we <= 1'b0;
      out_illegal  <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_rd       <= dec.dest;
      out_result   <= rot;
      out_rd_we    <= do_write;
      out_flags    <= nxt_flags;
      out_flags_we <= do_flags;
      out_illegal  <= !dec.legal;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_rd_we) && $stable(out_rd)));

  assert_zero_amount_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && in_amount[AW-1:0] == '0) |=> (out_result == $past(in_value)));

  assert_v_kept_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_flags[0] == $past(in_flags[0])));

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_rd_we && !out_flags_we));

  assert_nz_track_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flags_we) |->
      (out_flags[3] == out_result[W-1] && out_flags[2] == (out_result == '0)));

  assert_cond_block_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_cond_pass) |=> (!out_rd_we && !out_flags_we));
endmodule

// File: tb/rorx_exec_unit_test.sv
module rorx_exec_unit_test;
  localparam int PERIOD = 10;
  localparam int RAND_TXN = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_instr, in_value, in_amount;
  logic [3:0]  in_flags;
  logic        in_cond_pass;
  logic        out_valid, out_ready;
  logic [3:0]  out_rd;
  logic [31:0] out_result;
  logic        out_rd_we;
  logic [3:0]  out_flags;
  logic        out_flags_we, out_illegal;

  int checks = 0;
  int errors = 0;

  // behavioural model of the output register
  logic        e_valid;
  logic [3:0]  e_rd, e_flags;
  logic [31:0] e_result;
  logic        e_rd_we, e_flags_we, e_illegal;
  int          e_amt;
  logic        e_legal, e_pass, e_s;

  always #(PERIOD/2) clk = ~clk;

  rorx_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_value(in_value), .in_amount(in_amount),
    .in_flags(in_flags), .in_cond_pass(in_cond_pass), .out_valid(out_valid),
    .out_ready(out_ready), .out_rd(out_rd), .out_result(out_result),
    .out_rd_we(out_rd_we), .out_flags(out_flags), .out_flags_we(out_flags_we),
    .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cnd, input logic s,
      input logic [3:0] rd, input logic [3:0] rs, input logic [3:0] rm);
    return {cnd, 5'b00011, 2'b01, s, 4'b0000, rd, rs, 1'b0, 2'b11, 1'b1, rm};
  endfunction

  function automatic logic [31:0] ref_rot(input logic [31:0] v, input int n);
    logic [63:0] dbl;
    dbl = {v, v} >> n;
    return dbl[31:0];
  endfunction

  task automatic compare_outputs();
    string ftag;
    check("R10", "out_valid", 32'(out_valid), 32'(e_valid));
    check("R10", "in_ready", 32'(in_ready), 32'(!e_valid || out_ready));
    if (e_valid) begin
      check(e_amt == 0 ? "R2" : "R1", "result", out_result, e_result);
      check("R7", "rd", 32'(out_rd), 32'(e_rd));
      check(!e_legal ? "R8" : (!e_pass ? "R9" : "R7"), "rd_we",
            32'(out_rd_we), 32'(e_rd_we));
      check("R8", "illegal", 32'(out_illegal), 32'(e_illegal));
      ftag = !e_legal ? "R8" : (!e_pass ? "R9" : (!e_s ? "R5" : "R4"));
      check(ftag, "flags_we", 32'(out_flags_we), 32'(e_flags_we));
      check(ftag, "flags NZ", 32'(out_flags[3:2]), 32'(e_flags[3:2]));
      if (e_flags_we)
        check(e_amt == 0 ? "R2" : "R3", "carry", 32'(out_flags[1]), 32'(e_flags[1]));
      else
        check(ftag, "carry", 32'(out_flags[1]), 32'(e_flags[1]));
      check("R6", "V", 32'(out_flags[0]), 32'(e_flags[0]));
    end
  endtask

  // one cycle: compare at the falling edge, then drive and advance the model
  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] val,
                      input logic [31:0] amt, input logic [3:0] flg, input logic pass,
                      input logic rdy, output logic taken);
    logic [31:0] r;
    logic        cy, upd;
    int          n;
    @(negedge clk);
    out_ready = rdy;
    #1;
    compare_outputs();
    in_valid = v; in_instr = ins; in_value = val; in_amount = amt;
    in_flags = flg; in_cond_pass = pass;
    taken = v && (!e_valid || rdy);
    if (taken) begin
      n = int'(amt & 32'hFF) % 32;
      r = ref_rot(val, n);
      cy = (n == 0) ? flg[1] : val[n-1];
      e_legal = ((ins & 32'h0FEF00F0) == 32'h01A00070);
      e_pass = pass;
      e_s = ins[20];
      upd = e_legal && pass && e_s;
      e_valid = 1'b1; e_amt = n; e_result = r; e_rd = ins[15:12];
      e_rd_we = e_legal && pass; e_illegal = !e_legal; e_flags_we = upd;
      e_flags = upd ? {r[31], r == 32'd0, cy, flg[0]} : flg;
    end else if (rdy) begin
      e_valid = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] ins, input logic [31:0] val,
                      input logic [31:0] amt, input logic [3:0] flg, input logic pass);
    logic t;
    t = 1'b0;
    while (!t) step(1'b1, ins, val, amt, flg, pass, ($urandom % 4) != 0, t);
  endtask

  initial begin
    logic t;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_instr = '0; in_value = '0;
    in_amount = '0; in_flags = '0; in_cond_pass = 1'b0;
    e_valid = 1'b0; e_amt = 0; e_legal = 1'b0; e_pass = 1'b0; e_s = 1'b0;
    e_rd = '0; e_result = '0; e_rd_we = 1'b0; e_flags = '0; e_flags_we = 1'b0;
    e_illegal = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11", "out_valid", 32'(out_valid), 0);
    check("R11", "result", out_result, 0);
    check("R11", "rd_we", 32'(out_rd_we), 0);
    check("R11", "flags_we", 32'(out_flags_we), 0);
    rst = 1'b0;

    // directed corners
    send(mk(4'hE, 1'b1, 4'd3, 4'd6, 4'd2), 32'h8000_0001, 32'd0,   4'b0010, 1'b1); // R2 zero, C kept
    send(mk(4'hE, 1'b1, 4'd4, 4'd6, 4'd2), 32'h1234_5678, 32'd32,  4'b0001, 1'b1); // R1 32 -> 0
    send(mk(4'h0, 1'b1, 4'd5, 4'd6, 4'd2), 32'h0000_0001, 32'd257, 4'b0000, 1'b1); // R3 257 -> 1
    send(mk(4'hE, 1'b1, 4'd6, 4'd6, 4'd2), 32'hFFFF_0000, 32'd16,  4'b0000, 1'b1); // R1 half
    send(mk(4'hE, 1'b1, 4'd7, 4'd6, 4'd2), 32'h0000_0002, 32'd31,  4'b0001, 1'b1); // R3 top
    send(mk(4'hE, 1'b1, 4'd8, 4'd6, 4'd2), 32'h0000_0000, 32'd5,   4'b1010, 1'b1); // R4 zero result
    send(mk(4'hE, 1'b0, 4'd9, 4'd6, 4'd2), 32'h8000_0000, 32'd3,   4'b0101, 1'b1); // R5 no S
    send(mk(4'hE, 1'b1, 4'd1, 4'd6, 4'd2) ^ 32'h0000_0080, 32'h5, 32'd1, 4'b0110, 1'b1); // R8
    send(mk(4'hE, 1'b1, 4'd1, 4'd6, 4'd2) ^ 32'h0001_0000, 32'h5, 32'd1, 4'b0110, 1'b1); // R8
    send(mk(4'hE, 1'b1, 4'd2, 4'd6, 4'd2), 32'h0000_00F0, 32'd4,  4'b1111, 1'b0); // R9

    // random run with back-pressure
    for (int i = 0; i < RAND_TXN; i++) begin
      logic [31:0] ins;
      logic [31:0] amt;
      ins = mk(4'($urandom), 1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
      if (($urandom % 8) == 0) ins = ins ^ (32'h1 << ($urandom % 32));
      amt = $urandom;
      if (($urandom % 6) == 0) amt = amt & 32'hFFFF_FFE0;
      if (($urandom % 3) == 0) step(1'b0, ins, $urandom, amt, 4'($urandom), 1'b1,
                                    ($urandom % 3) != 0, t);
      else send(ins, (($urandom % 10) == 0) ? 32'd0 : $urandom, amt, 4'($urandom),
                ($urandom % 5) != 0);
    end
    repeat (3) step(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, t);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule